// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block runs a 16-bit successive-approximation converter that returns its result on a parallel bus and reports progress on a single busy line. Working from a fast system clock, it issues a periodic sample command at one of two selectable rates. It also produces the conversion clock. That clock is held low with its divider cleared whenever the converter's busy line is low, which is during acquisition. It starts running once busy rises.

Each conversion takes exactly seventeen conversion-clock pulses. The sequencer counts them and parks the clock low after the seventeenth, so a late busy fall never causes an eighteenth pulse. The busy line is brought into the system-clock domain through a two-flop synchronizer. On its falling edge the data bus is captured, recoded to two's complement or offset binary as selected, and presented with a one-cycle valid strobe.

A watchdog times each conversion from the rise of the sample command to the fall of busy. If the time exceeds a parameterised limit, the watchdog sets a sticky timeout flag. That limit defaults to 1000 microseconds at a 12.288 MHz system clock.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While reset is asserted, sample_o, cnv_clk_o, result_valid_o and timeout_o are 0 and result_o is 0.
- R2: The sample command rises once every 128 system-clock cycles when rate_sel_i is 0 and once every 256 cycles when rate_sel_i is 1.
- R3: Each sample-command pulse stays high for exactly SAMPLE_HI (default 8) system-clock cycles.
- R4: cnv_clk_o never rises while the converter's busy line is low; the clock stays low throughout acquisition.
- R5: Every conversion receives exactly 17 rising edges on cnv_clk_o, and none after the 17th until busy has fallen and risen again.
- R6: Within a conversion, consecutive rising edges of cnv_clk_o are CLK_LO+CLK_HI (default 4) cycles apart, and each of the first 16 high phases lasts CLK_HI (default 2) cycles, so the low phase is at least half the high phase.
- R7: After busy falls, result_o takes the data bus value and result_valid_o pulses. With fmt_sel_i = 0 the value is passed unchanged as two's complement. result_o changes only together with result_valid_o.
- R8: With fmt_sel_i = 1 the captured word has bit 15 inverted and bits 14:0 unchanged (offset binary).
- R9: result_valid_o is high for exactly one system-clock cycle per finished conversion, and never without one.
- R10: If busy has not fallen within WD_LIMIT (default 12288) system-clock cycles of the sample-command rise, timeout_o goes to 1 and stays 1 until reset. Before that limit it remains 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnv_busy_i | input | 1 | Converter busy line, asynchronous, high while converting |
| cnv_data_i | input | 16 | Converter parallel result, two's complement |
| rate_sel_i | input | 1 | 0: sample every 128 cycles, 1: every 256 cycles |
| fmt_sel_i | input | 1 | 0: two's complement out, 1: offset binary out |
| sample_o | output | 1 | Sample command to the converter |
| cnv_clk_o | output | 1 | Gated conversion clock |
| result_o | output | 16 | Last captured and recoded result |
| result_valid_o | output | 1 | One-cycle strobe for a new result |
| timeout_o | output | 1 | Sticky flag for an over-long conversion |

## Verification
A corrupted pulse counter in the clock generator shows up at once as an extra or missing conversion-clock edge. Such a fault either stalls the modelled converter, which starves the result stream and trips the bench watchdog, or produces an edge while busy is low within the same conversion. A wrong divider or rate counter is visible at the next clock or sample edge as a wrong spacing or width. A bad capture or format path appears as a result mismatch on the very next valid strobe. A watchdog counter that starts or stops at the wrong time moves the timeout rise outside a narrow window around the limit during the stalled conversion.

// File: rtl/adc_ctrl_pkg.sv
`timescale 1ns/1ps
package adc_ctrl_pkg;

    localparam int unsigned DATA_W     = 16;
    localparam int unsigned CNV_PULSES = 17;

    typedef logic [DATA_W-1:0] sample_t;

    typedef enum logic {
        FMT_TWOS   = 1'b0,
        FMT_OFFSET = 1'b1
    } fmt_e;

    typedef enum logic {
        RATE_FAST = 1'b0,
        RATE_SLOW = 1'b1
    } rate_e;

    typedef struct packed {
        logic level;
        logic fall;
    } busy_ev_t;

    function automatic sample_t recode(sample_t raw, fmt_e fmt);
        sample_t res;
        res = raw;
        if (fmt == FMT_OFFSET) begin
            res[DATA_W-1] = ~raw[DATA_W-1];
        end
        return res;
    endfunction

endpackage

// File: rtl/sample_rate_gen.sv
`timescale 1ns/1ps
module sample_rate_gen
    import adc_ctrl_pkg::*;
#(
    parameter int unsigned DIV_FAST  = 128,
    parameter int unsigned DIV_SLOW  = 256,
    parameter int unsigned SAMPLE_HI = 8
) (
    input  logic  clk,
    input  logic  rst,
    input  rate_e rate,
    output logic  sample
);
    localparam int unsigned CW = $clog2(DIV_SLOW + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last_q;

    always_comb begin
        last_q = (rate == RATE_SLOW) ? CW'(DIV_SLOW - 1) : CW'(DIV_FAST - 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            sample <= 1'b0;
        end else begin
            cnt_q  <= (cnt_q >= last_q) ? '0 : cnt_q + 1'b1;
            sample <= (cnt_q < CW'(SAMPLE_HI));
        end
    end
endmodule

// File: rtl/cnv_clk_gen.sv
`timescale 1ns/1ps
module cnv_clk_gen
    import adc_ctrl_pkg::*;
#(
    parameter int unsigned CLK_LO = 2,
    parameter int unsigned CLK_HI = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic busy,
    output logic cnv_clk
);
    localparam int unsigned DIV = CLK_LO + CLK_HI;
    localparam int unsigned CW  = $clog2(DIV + 1);
    localparam int unsigned PW  = $clog2(CNV_PULSES + 1);

    logic [CW-1:0] div_q, div_nxt;
    logic [PW-1:0] rises_q;
    logic          done_q;
    logic          clk_nxt;

    always_comb begin
        div_nxt = (div_q == CW'(DIV - 1)) ? '0 : div_q + 1'b1;
        clk_nxt = (div_nxt >= CW'(CLK_LO));
    end

    always_ff @(posedge clk) begin
        if (rst || !busy) begin
            div_q   <= '0;
            rises_q <= '0;
            done_q  <= 1'b0;
            cnv_clk <= 1'b0;
        end else if (!done_q) begin
            div_q   <= div_nxt;
            cnv_clk <= clk_nxt;
            if (clk_nxt && !cnv_clk) begin
                rises_q <= rises_q + 1'b1;
            end
            if (!clk_nxt && cnv_clk && rises_q == PW'(CNV_PULSES)) begin
                done_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/result_capture.sv
`timescale 1ns/1ps
module result_capture
    import adc_ctrl_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    capture,
    input  sample_t raw,
    input  fmt_e    fmt,
    output sample_t result,
    output logic    valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            result <= '0;
            valid  <= 1'b0;
        end else begin
            valid <= capture;
            if (capture) begin
                result <= recode(raw, fmt);
            end
        end
    end
endmodule

// File: rtl/conv_watchdog.sv
`timescale 1ns/1ps
module conv_watchdog #(
    parameter int unsigned WD_LIMIT = 12288
) (
    input  logic clk,
    input  logic rst,
    input  logic sample,
    input  logic busy_fall,
    output logic timeout
);
    localparam int unsigned CW = $clog2(WD_LIMIT + 1);

    logic          sample_q;
    logic          run_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sample_q <= 1'b0;
            run_q    <= 1'b0;
            cnt_q    <= '0;
            timeout  <= 1'b0;
        end else begin
            sample_q <= sample;
            if (busy_fall) begin
                run_q <= sample;
                cnt_q <= '0;
            end else if (sample && !sample_q && !run_q) begin
                run_q <= 1'b1;
                cnt_q <= '0;
            end else if (run_q && cnt_q != CW'(WD_LIMIT)) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (run_q && !busy_fall && cnt_q == CW'(WD_LIMIT - 1)) begin
                timeout <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
module adc_seq_ctrl
    import adc_ctrl_pkg::*;
#(
    parameter int unsigned DIV_FAST    = 128,
    parameter int unsigned DIV_SLOW    = 256,
    parameter int unsigned SAMPLE_HI   = 8,
    parameter int unsigned CLK_LO      = 2,
    parameter int unsigned CLK_HI      = 2,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned WD_LIMIT    = 12288
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cnv_busy_i,
    input  logic [DATA_W-1:0] cnv_data_i,
    input  logic              rate_sel_i,
    input  logic              fmt_sel_i,
    output logic              sample_o,
    output logic              cnv_clk_o,
    output logic [DATA_W-1:0] result_o,
    output logic              result_valid_o,
    output logic              timeout_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   busy_last_q;
    logic                   busy_sync;
    busy_ev_t               busy_ev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q      <= '0;
            busy_last_q <= 1'b0;
        end else begin
            sync_q      <= {sync_q[SYNC_STAGES-2:0], cnv_busy_i};
            busy_last_q <= sync_q[SYNC_STAGES-1];
        end
    end

    always_comb begin
        busy_sync     = sync_q[SYNC_STAGES-1];
        busy_ev.level = busy_sync;
        busy_ev.fall  = busy_last_q && !busy_sync;
    end

    sample_rate_gen #(
        .DIV_FAST (DIV_FAST),
        .DIV_SLOW (DIV_SLOW),
        .SAMPLE_HI(SAMPLE_HI)
    ) rate_i (
        .clk   (clk),
        .rst   (rst),
        .rate  (rate_e'(rate_sel_i)),
        .sample(sample_o)
    );

    cnv_clk_gen #(
        .CLK_LO(CLK_LO),
        .CLK_HI(CLK_HI)
    ) ckgen_i (
        .clk    (clk),
        .rst    (rst),
        .busy   (busy_ev.level),
        .cnv_clk(cnv_clk_o)
    );

    result_capture cap_i (
        .clk    (clk),
        .rst    (rst),
        .capture(busy_ev.fall),
        .raw    (cnv_data_i),
        .fmt    (fmt_e'(fmt_sel_i)),
        .result (result_o),
        .valid  (result_valid_o)
    );

    conv_watchdog #(
        .WD_LIMIT(WD_LIMIT)
    ) wd_i (
        .clk      (clk),
        .rst      (rst),
        .sample   (sample_o),
        .busy_fall(busy_ev.fall),
        .timeout  (timeout_o)
    );
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
`timescale 1ns/1ps
module adc_seq_ctrl_chk #(
    parameter int unsigned SAMPLE_HI = 8,
    parameter int unsigned CLK_HI    = 2
) (
    input logic        clk,
    input logic        rst,
    input logic        busy_s,
    input logic        sample_o,
    input logic        cnv_clk_o,
    input logic [15:0] result_o,
    input logic        result_valid_o,
    input logic        timeout_o
);
    logic [15:0] s_hi_q;
    logic [15:0] c_hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_hi_q <= '0;
            c_hi_q <= '0;
        end else begin
            s_hi_q <= sample_o  ? s_hi_q + 1'b1 : '0;
            c_hi_q <= cnv_clk_o ? c_hi_q + 1'b1 : '0;
        end
    end

    assert_sample_width_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(sample_o) |-> (s_hi_q == 16'(SAMPLE_HI)));

    assert_sample_max_R3: assert property (@(posedge clk) disable iff (rst)
        s_hi_q <= 16'(SAMPLE_HI));

    assert_clk_idle_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(cnv_clk_o) |-> $past(busy_s));

    assert_clk_high_R6: assert property (@(posedge clk) disable iff (rst)
        c_hi_q <= 16'(CLK_HI));

    assert_result_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(result_o) |-> result_valid_o);

    assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        result_valid_o |=> !result_valid_o);

    assert_timeout_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        timeout_o |=> timeout_o);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(
    .SAMPLE_HI(SAMPLE_HI),
    .CLK_HI   (CLK_HI)
) chk_i (
    .clk           (clk),
    .rst           (rst),
    .busy_s        (busy_sync),
    .sample_o      (sample_o),
    .cnv_clk_o     (cnv_clk_o),
    .result_o      (result_o),
    .result_valid_o(result_valid_o),
    .timeout_o     (timeout_o)
);

// File: tb/adc_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_seq_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_FAST   = 128;
    localparam int DIV_SLOW   = 256;
    localparam int SAMPLE_HI  = 8;
    localparam int CLK_LO     = 2;
    localparam int CLK_HI     = 2;
    localparam int PULSES     = 17;
    localparam int WD_LIMIT   = 12288;
    localparam int MAX_CYC    = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        busy = 1'b0;
    logic [15:0] data = 16'h0;
    logic        rate_sel = 1'b0;
    logic        fmt_sel = 1'b0;
    logic        sample_o, cnv_clk_o, result_valid_o, timeout_o;
    logic [15:0] result_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_seq_ctrl dut_i (
        .clk           (clk),
        .rst           (rst),
        .cnv_busy_i    (busy),
        .cnv_data_i    (data),
        .rate_sel_i    (rate_sel),
        .fmt_sel_i     (fmt_sel),
        .sample_o      (sample_o),
        .cnv_clk_o     (cnv_clk_o),
        .result_o      (result_o),
        .result_valid_o(result_valid_o),
        .timeout_o     (timeout_o)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done_flag = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    function automatic logic [15:0] pattern(int k);
        case (k % 6)
            0: pattern = 16'h7FFF;
            1: pattern = 16'h8000;
            2: pattern = 16'h0000;
            3: pattern = 16'hFFFF;
            4: pattern = 16'h0001;
            default: pattern = 16'(k * 4951);
        endcase
    endfunction

    // scoreboard queue: {fmt, raw}
    logic [16:0] expq[$];
    int results = 0;
    int conv_idx = 0;

    int cyc = 0;
    logic p_sample = 0, p_clk = 0, p_valid = 0;
    int rises = 0, last_rise = 0, hi_len = 0, s_hi = 0, last_srise = -1;
    bit skip_period = 1;
    bit stall = 0;
    bit release_req = 0;

    // converter model, driver and monitor
    always @(negedge clk) begin
        logic [16:0] e;
        logic [15:0] expv;
        cyc++;
        if (rst) begin
            busy <= 1'b0;
            rises = 0;
            last_srise = -1;
            skip_period = 1;
            p_sample = 0;
            p_clk = 0;
            p_valid = 0;
            s_hi = 0;
            hi_len = 0;
        end else begin
            if (sample_o && !p_sample) begin
                if (last_srise >= 0 && !skip_period)
                    check(cyc - last_srise == (rate_sel ? DIV_SLOW : DIV_FAST), "R2 sample period",
                          cyc - last_srise, rate_sel ? DIV_SLOW : DIV_FAST);
                skip_period = 0;
                last_srise = cyc;
                s_hi = 0;
            end
            if (sample_o) s_hi++;
            if (!sample_o && p_sample)
                check(s_hi == SAMPLE_HI, "R3 sample width", s_hi, SAMPLE_HI);
            if (!sample_o && p_sample && !busy) begin
                busy <= 1'b1;
                rises = 0;
            end

            if (cnv_clk_o && !p_clk) begin
                check(busy == 1'b1, "R4 clock edge during acquisition", busy, 1);
                rises++;
                if (rises > 1)
                    check(cyc - last_rise == CLK_LO + CLK_HI, "R6 rise spacing",
                          cyc - last_rise, CLK_LO + CLK_HI);
                last_rise = cyc;
                hi_len = 0;
            end
            if (cnv_clk_o) hi_len++;
            if (!cnv_clk_o && p_clk && busy && rises < PULSES)
                check(hi_len == CLK_HI, "R6 high phase", hi_len, CLK_HI);

            if (busy && ((rises == PULSES && cnv_clk_o && !p_clk && !stall) || release_req)) begin
                check(rises == PULSES, "R5 pulses per conversion", rises, PULSES);
                busy <= 1'b0;
                data <= pattern(conv_idx);
                expq.push_back({fmt_sel, pattern(conv_idx)});
                conv_idx++;
                release_req = 0;
            end

            if (result_valid_o) begin
                check(!p_valid, "R9 valid longer than one cycle", p_valid, 0);
                if (expq.size() == 0) begin
                    check(0, "R9 valid without conversion", 1, 0);
                end else begin
                    e = expq.pop_front();
                    expv = e[16] ? {~e[15], e[14:0]} : e[15:0];
                    check(result_o == expv, e[16] ? "R8 offset binary result" : "R7 twos complement result",
                          result_o, expv);
                    results++;
                end
            end
            p_sample = sample_o;
            p_clk = cnv_clk_o;
            p_valid = result_valid_o;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(sample_o == 0, "R1 reset sample", sample_o, 0);
        check(cnv_clk_o == 0, "R1 reset clock", cnv_clk_o, 0);
        check(result_valid_o == 0, "R1 reset valid", result_valid_o, 0);
        check(timeout_o == 0, "R1 reset timeout", timeout_o, 0);
        check(result_o == 0, "R1 reset result", result_o, 0);
        @(posedge clk);
        rst <= 1'b0;

        wait (results == 6);
        @(posedge clk);
        fmt_sel <= 1'b1;
        wait (results == 12);
        @(posedge clk);
        rate_sel <= 1'b1;
        skip_period = 1;
        wait (results == 16);
        @(posedge clk);
        fmt_sel <= 1'b0;
        rate_sel <= 1'b0;
        skip_period = 1;
        wait (results == 18);
        check(timeout_o == 0, "R10 no timeout on normal conversions", timeout_o, 0);

        // stalled conversion for the watchdog
        @(posedge clk);
        stall = 1;
        wait (busy == 1'b1);
        repeat (WD_LIMIT - 20) @(negedge clk);
        check(timeout_o == 0, "R10 timeout before limit", timeout_o, 0);
        repeat (40) @(negedge clk);
        check(timeout_o == 1, "R10 timeout after limit", timeout_o, 1);
        @(posedge clk);
        stall = 0;
        release_req = 1;
        wait (results == 19);
        repeat (300) @(negedge clk);
        check(timeout_o == 1, "R10 timeout sticky", timeout_o, 1);
        wait (results == 21);
        @(negedge clk);
        check(conv_idx == results, "R9 one valid per conversion", results, conv_idx);

        @(posedge clk);
        rst <= 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(timeout_o == 0, "R1 R10 timeout cleared by reset", timeout_o, 0);
        check(sample_o == 0, "R1 sample in reset", sample_o, 0);
        check(result_valid_o == 0, "R1 valid in reset", result_valid_o, 0);
        check(result_o == 0, "R1 result in reset", result_o, 0);
        finish_run();
    end

    initial begin
        repeat (MAX_CYC) @(posedge clk);
        check(0, "watchdog expired", results, 21);
        finish_run();
    end
endmodule